// File: doc/BRIEF.md
# Change-Triggered Reloading Delay Timer

This block is a clocked delay timer driven by a single multi-bit value. It samples the value on every clock edge and keeps the previous sample. When the current value differs from that sample, the block treats the value as a new delay request. It loads an internal down-counter with the value itself, so the value is also the delay length. There is no separate load strobe.

The counter decrements by one on every following edge and stops at zero. The `ready` output is high whenever the counter is zero and low while a countdown runs. A client that wants a delay of N cycles changes the value to N and waits for `ready`. A further change during a countdown restarts it with the newest value. The whole timer is plain clocked logic that any synthesis flow can map.

Top module: `chg_delay_timer`

## Requirements
- R1: A clock edge with `rst_n` low clears the counter and the stored previous value to zero. `ready` is therefore high after that edge, and the first edge after reset treats any nonzero value as a change.
- R2: When `delay_val` differs from the value sampled at the previous edge and is nonzero, `ready` is low right after the edge that sees the change.
- R3: After a load of a nonzero value N with `delay_val` held steady, `ready` stays low for N-1 further edges and goes high on exactly the Nth edge after the load edge.
- R4: A change of `delay_val` during a countdown reloads the counter with the newest value, and the N-edge timing of R3 restarts from that edge.
- R5: A change of `delay_val` to zero leaves the counter at zero, so `ready` shows no low cycle.
- R6: Holding `delay_val` unchanged never reloads the counter. Once `ready` is high, it stays high while the value is unchanged.
- R7: The counter holds at zero and never wraps below it.
- R8: The delay spans the full width of `delay_val`. The all-ones value 2^VAL_W-1 gives that many low-ready edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| delay_val | input | VAL_W | Requested delay in clock cycles; a change starts a new delay |
| ready | output | 1 | High while no delay is in progress |

## Verification
The bench builds the timer with its default width VAL_W = 8. At that width the full-scale delay of 255 cycles is short enough to run to completion, so the R8 boundary is covered. It also lets a reload in the middle of a long countdown be watched on both sides of the restart. The bench tracks expected `ready` on every cycle from the load edge and the requested length alone. This covers zero requests, repeated identical values, and a reset that arrives mid-countdown while the input stays at a nonzero value.

// File: rtl/chg_delay_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the change-triggered delay timer.
// Assumes: nothing beyond IEEE 1800-2017.
package chg_delay_pkg;

    // Action applied to the down-counter on a clock edge.
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_action_e;

endpackage

// File: rtl/chg_detect.sv
`timescale 1ns/1ps
// Module: chg_detect
// Keeps the value sampled on the previous clock edge and flags a change
// when the present value differs from it.
// Assumes: delay_val is synchronous to clk; reset is synchronous, active low.
module chg_detect #(
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] cur_val,
    output logic [VAL_W-1:0] prev_val,
    output logic             changed
);

    logic [VAL_W-1:0] prev_q;

    // Purpose: record the value seen on each edge; reset clears it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_val;
    end

    // Purpose: compare the present value against the recorded one.
    always_comb begin
        changed = (cur_val != prev_q);
    end

    assign prev_val = prev_q;

endmodule

// File: rtl/delay_downcounter.sv
`timescale 1ns/1ps
// Module: delay_downcounter
// Down-counter that loads a new length on request, otherwise counts
// toward zero and saturates there.
// Assumes: a load request has priority over decrementing.
module delay_downcounter
    import chg_delay_pkg::*;
#(
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VAL_W-1:0] load_val,
    output logic [VAL_W-1:0] count,
    output logic             is_zero
);

    localparam logic [VAL_W-1:0] ONE = {{(VAL_W-1){1'b0}}, 1'b1};

    logic [VAL_W-1:0] cnt_q;
    cnt_action_e      action;

    // Purpose: choose load, decrement or hold for this edge.
    always_comb begin
        if (load)             action = CNT_LOAD;
        else if (cnt_q != '0) action = CNT_DEC;
        else                  action = CNT_HOLD;
    end

    // Purpose: apply the chosen action; reset clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (action)
                CNT_LOAD: cnt_q <= load_val;
                CNT_DEC:  cnt_q <= cnt_q - ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // Purpose: flag the idle (zero) state.
    always_comb begin
        is_zero = ~|cnt_q;
    end

    assign count = cnt_q;

endmodule

// File: rtl/ready_gen.sv
`timescale 1ns/1ps
// Module: ready_gen
// Turns the counter's zero flag into the ready output.
// Assumes: the zero flag comes straight from the counter register.
module ready_gen (
    input  logic cnt_zero,
    output logic ready
);

    // Purpose: ready is high exactly while no delay is running.
    always_comb begin
        ready = cnt_zero;
    end

endmodule

// File: rtl/chg_delay_timer.sv
`timescale 1ns/1ps
// Module: chg_delay_timer (top)
// Delay timer started by any change of its value input; the new value is
// the delay length in clock cycles and ready is low while it runs.
// Assumes: delay_val is synchronous to clk; rst_n is synchronous, active low.
module chg_delay_timer #(
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] delay_val,
    output logic             ready
);

    logic [VAL_W-1:0] prev_q;
    logic             val_changed;
    logic [VAL_W-1:0] cnt_q;
    logic             cnt_zero;

    chg_detect #(.VAL_W(VAL_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_val  (delay_val),
        .prev_val (prev_q),
        .changed  (val_changed)
    );

    delay_downcounter #(.VAL_W(VAL_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (val_changed),
        .load_val (delay_val),
        .count    (cnt_q),
        .is_zero  (cnt_zero)
    );

    ready_gen u_ready (
        .cnt_zero (cnt_zero),
        .ready    (ready)
    );

endmodule

// File: rtl/chg_delay_timer_chk.sv
`timescale 1ns/1ps
// Module: chg_delay_timer_chk
// Property checker bound into chg_delay_timer.
// Assumes: count and prev are the top's counter and previous-value registers.
module chg_delay_timer_chk #(
    parameter int VAL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VAL_W-1:0] delay_val,
    input logic             ready,
    input logic [VAL_W-1:0] count,
    input logic [VAL_W-1:0] prev
);

    // R1: a reset edge leaves both registers cleared and ready high
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && prev == '0 && ready));

    // R2 / R4: a change loads the counter with the new value
    a_r2_change_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_val != prev) |=> (count == $past(delay_val)));

    // R2: a change to a nonzero value drops ready on the next cycle
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_val != prev && delay_val != '0) |=> !ready);

    // R3: with a steady input a running count drops by exactly one
    a_r3_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_val == prev && count != '0) |=> (count == $past(count) - 1'b1));

    // R7: with a steady input zero holds and ready stays high
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_val == prev && count == '0) |=> (count == '0 && ready));

endmodule

bind chg_delay_timer chg_delay_timer_chk #(.VAL_W(VAL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .delay_val (delay_val),
    .ready     (ready),
    .count     (cnt_q),
    .prev      (prev_q)
);

// File: tb/tb_chg_delay_timer.sv
`timescale 1ns/1ps
module tb_chg_delay_timer;

    localparam int CLK_PERIOD = 10;
    localparam int VAL_W      = 8;
    localparam int NVEC       = 10;
    // stimulus table: value applied, number of cycles it is held
    localparam int VEC_VAL [NVEC] = '{3, 3, 0, 5, 1, 7, 0, 0, 2, 2};
    localparam int VEC_LEN [NVEC] = '{6, 2, 3, 8, 3, 10, 2, 3, 4, 3};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [VAL_W-1:0] delay_val = '0;
    logic             ready;

    int checks = 0;
    int failures = 0;
    int prev_m = 0;
    int load_m = 0;
    int since_m = 0;
    bit done = 1'b0;

    chg_delay_timer #(.VAL_W(VAL_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .delay_val (delay_val),
        .ready     (ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: ready actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one value for one edge, update the expected model, check ready.
    task automatic step(input int v, input bit rst, input string tag);
        string req;
        bit    chg;
        logic  exp;
        @(negedge clk);
        delay_val = v[VAL_W-1:0];
        rst_n     = !rst;
        @(posedge clk);
        #1;
        chg = 1'b0;
        if (rst) begin
            prev_m = 0; load_m = 0; since_m = 0;
        end else begin
            if (v != prev_m) begin
                load_m = v; since_m = 0; chg = 1'b1;
            end else begin
                since_m++;
            end
            prev_m = v;
        end
        exp = (since_m >= load_m);
        if (tag != "")                   req = tag;
        else if (rst)                    req = "R1";
        else if (chg && v == 0)          req = "R5";
        else if (chg)                    req = "R2";
        else if (since_m < load_m)       req = "R3";
        else if (load_m != 0)            req = "R7";
        else                             req = "R6";
        check(ready, exp, req);
    endtask

    initial begin
        // R1: reset state
        step(0, 1'b1, "R1");
        step(0, 1'b1, "R1");
        step(0, 1'b0, "R1");

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < VEC_LEN[i]; k++) step(VEC_VAL[i], 1'b0, "");
        end

        // R4: reload mid-countdown restarts timing
        for (int k = 0; k < 4; k++)  step(20, 1'b0, "");
        for (int k = 0; k < 12; k++) step(9, 1'b0, "R4");
        // R6: same value held long after finishing never reloads
        for (int k = 0; k < 5; k++)  step(9, 1'b0, "R6");

        // R8: full-scale delay
        for (int k = 0; k < 258; k++) step(255, 1'b0, "R8");

        // R1: reset mid-countdown with input held nonzero
        for (int k = 0; k < 4; k++) step(200, 1'b0, "");
        step(200, 1'b1, "R1");
        // first edge after reset sees 200 as a change (previous cleared)
        for (int k = 0; k < 3; k++) step(200, 1'b0, "R1");

        // R5: zero request right after a nonzero one
        step(4, 1'b0, "");
        step(0, 1'b0, "R5");
        for (int k = 0; k < 3; k++) step(0, 1'b0, "R5");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule